// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

This block measures a digital waveform on one of two input pins. A prescaler divides the clock and feeds a free-running up-counter that wraps at a programmable limit. The selected pin is synchronized, and its active edge does two things in the same cycle: it latches the running count into one capture register and restarts the counter from zero. The opposite edge latches the count into the other capture register. After each active edge, one capture therefore holds the period of the waveform and the other holds the duration of its active phase, both in prescaled ticks.

Software programs the block through a small word-addressed write/read port. It picks the pin and the active polarity, then starts counting. It reads the two captures after a flag or an interrupt. Each capture and the counter wrap have a status flag, and each flag has an enable. The interrupt output is the OR of the enabled flags. A capture that lands while its flag is still set is recorded in a separate over-capture bit.

Top module: `pwcap_timer`

## Requirements
- R1: After reset every register reads 0, including the limit, counter and both captures, and `irq` is low.
- R2: The counter advances once every PSC+1 clocks, where PSC is the 16-bit prescaler register at byte offset 0x0C. A new PSC value takes effect only after an update-generate or a counter wrap.
- R3: A limit register value of 0 (byte offset 0x10) acts as the all-ones limit. The counter keeps counting past small values and the wrap flag stays clear.
- R4: When the counter is at the limit and a tick arrives, it returns to 0 and sets the wrap flag (status bit 2).
- R5: Writing control (offset 0x00) with bit 3 set clears the counter and the prescaler phase and loads PSC. It does not set the wrap flag. Bit 3 always reads 0.
- R6: Control bit 1 selects the pin. With 0, pin 0 is measured, capture A (offset 0x14) holds the period and capture B (offset 0x18) holds the width. With 1, pin 1 is measured and the roles of the two captures are swapped.
- R7: With control bit 2 clear, the active edge is rising and the width edge is falling. With bit 2 set, both polarities are swapped.
- R8: An active edge stores the current count in the period capture and restarts counter and prescaler. With the pin period N clocks and the active phase W clocks, the period capture reads floor((N-1)/(PSC+1)) and the width capture reads floor((W-1)/(PSC+1)).
- R9: Status flags (offset 0x04: bit 0 capture A, bit 1 capture B, bit 2 wrap, bit 3 over-capture A, bit 4 over-capture B) clear on a written 0. A written 1 leaves them unchanged.
- R10: `irq` is high exactly when one of status bits 0..2 is set together with the same bit of the enable register (offset 0x08).
- R11: While control bit 0 (run) is clear, the counter (offset 0x1C), both captures and the capture flags do not change, whatever the pins do.
- R12: A capture event that finds its flag already set overwrites the capture and sets the matching over-capture bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 2 | Asynchronous waveform inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a precise capture value through the synchronizer and the prescaler. The count seen at an edge depends on the prescaler phase, and that phase restarts only on the same edge being measured. The stimulus first loads PSC with an update-generate while the timer is stopped. It then drives three full cycles of the waveform, one clock at a time, so that the interval between captured edges is exact and the expected value follows from the floor formula alone. The unselected pin runs a different pattern during every vector, so a wrong route shows up as a wrong capture.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_PINS = 2;

    // register byte offsets
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_IEN  = 8'h08;
    localparam logic [7:0] OFS_PSC  = 8'h0C;
    localparam logic [7:0] OFS_LIM  = 8'h10;
    localparam logic [7:0] OFS_CAPA = 8'h14;
    localparam logic [7:0] OFS_CAPB = 8'h18;
    localparam logic [7:0] OFS_CNT  = 8'h1C;

    // control bits
    localparam int CTRL_RUN = 0;
    localparam int CTRL_SEL = 1;
    localparam int CTRL_LOW = 2;
    localparam int CTRL_UG  = 3;

    // status bits; bits 0..2 are the interrupt sources
    localparam int ST_W     = 5;
    localparam int ST_CAPA  = 0;
    localparam int ST_CAPB  = 1;
    localparam int ST_WRAP  = 2;
    localparam int ST_OCA   = 3;
    localparam int ST_OCB   = 4;
    localparam int IEN_W    = 3;

endpackage

// File: rtl/pwcap_edge_sync.sv
module pwcap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } es_t;

    es_t q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[STAGES-2:0], din};
        d.last = q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise = q.sh[STAGES-1] & ~q.last;
    assign fall = ~q.sh[STAGES-1] & q.last;
endmodule

// File: rtl/pwcap_prescaler.sv
module pwcap_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             load,
    input  logic [PSC_W-1:0] psc_in,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] div;
        logic [PSC_W-1:0] act;
    } pre_t;

    pre_t q, d;

    assign tick = run && (q.div == q.act);

    always_comb begin
        d = q;
        if (clr)      d.div = '0;
        else if (run) d.div = tick ? '0 : q.div + 1'b1;
        if (load)     d.act = psc_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pwcap_timer.sv
module pwcap_timer
    import pwcap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PSC_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = OFS_CTRL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_STAT = OFS_STAT[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_IEN  = OFS_IEN[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_PSC  = OFS_PSC[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_LIM  = OFS_LIM[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_CAPA = OFS_CAPA[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_CAPB = OFS_CAPB[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_CNT  = OFS_CNT[ADDR_W-1:0];

    typedef struct packed {
        logic             run;
        logic             sel;
        logic             act_low;
        logic [ST_W-1:0]  st;
        logic [IEN_W-1:0] ien;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] lim;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap_a;
        logic [CNT_W-1:0] cap_b;
    } tmr_t;

    tmr_t q, d;

    // edge detection per pin
    logic [NUM_PINS-1:0] rise_v, fall_v;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pwcap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin_in[p]),
            .rise (rise_v[p]),
            .fall (fall_v[p])
        );
    end

    // bus decode
    logic wr_ctrl, wr_stat, wr_ien, wr_psc, wr_lim, ug_req;
    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_stat = bus_we && (bus_addr == A_STAT);
    assign wr_ien  = bus_we && (bus_addr == A_IEN);
    assign wr_psc  = bus_we && (bus_addr == A_PSC);
    assign wr_lim  = bus_we && (bus_addr == A_LIM);
    assign ug_req  = wr_ctrl && bus_wdata[CTRL_UG];

    // edge routing: the selected pin feeds both channels
    logic rise_s, fall_s, per_evt, wid_evt, cap_a_evt, cap_b_evt;
    assign rise_s    = rise_v[q.sel];
    assign fall_s    = fall_v[q.sel];
    assign per_evt   = q.run && (q.act_low ? fall_s : rise_s);
    assign wid_evt   = q.run && (q.act_low ? rise_s : fall_s);
    assign cap_a_evt = q.sel ? wid_evt : per_evt;
    assign cap_b_evt = q.sel ? per_evt : wid_evt;

    logic [CNT_W-1:0] lim_eff;
    assign lim_eff = (q.lim == '0) ? '1 : q.lim;

    // prescaler
    logic tick, wrap, pre_clr, pre_load;
    assign pre_clr  = ug_req || per_evt;
    assign pre_load = ug_req || wrap;

    pwcap_prescaler #(.PSC_W(PSC_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.run),
        .clr   (pre_clr),
        .load  (pre_load),
        .psc_in(q.psc),
        .tick  (tick)
    );

    always_comb begin
        d    = q;
        wrap = 1'b0;

        if (wr_ctrl) begin
            d.run     = bus_wdata[CTRL_RUN];
            d.sel     = bus_wdata[CTRL_SEL];
            d.act_low = bus_wdata[CTRL_LOW];
        end
        if (wr_ien) d.ien = bus_wdata[IEN_W-1:0];
        if (wr_psc) d.psc = bus_wdata[PSC_W-1:0];
        if (wr_lim) d.lim = bus_wdata[CNT_W-1:0];
        if (wr_stat) d.st = q.st & bus_wdata[ST_W-1:0];

        // counter: update-generate, then slave reset, then tick
        if (ug_req || per_evt) begin
            d.cnt = '0;
        end else if (tick) begin
            if (q.cnt == lim_eff) begin
                d.cnt = '0;
                wrap  = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        // captures take the count before any restart
        if (cap_a_evt) begin
            d.cap_a      = q.cnt;
            d.st[ST_CAPA] = 1'b1;
            if (q.st[ST_CAPA]) d.st[ST_OCA] = 1'b1;
        end
        if (cap_b_evt) begin
            d.cap_b      = q.cnt;
            d.st[ST_CAPB] = 1'b1;
            if (q.st[ST_CAPB]) d.st[ST_OCB] = 1'b1;
        end
        if (wrap) d.st[ST_WRAP] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq = |(q.st[IEN_W-1:0] & q.ien);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[CTRL_RUN] = q.run;
                bus_rdata[CTRL_SEL] = q.sel;
                bus_rdata[CTRL_LOW] = q.act_low;
            end
            A_STAT:  bus_rdata[ST_W-1:0]  = q.st;
            A_IEN:   bus_rdata[IEN_W-1:0] = q.ien;
            A_PSC:   bus_rdata[PSC_W-1:0] = q.psc;
            A_LIM:   bus_rdata[CNT_W-1:0] = q.lim;
            A_CAPA:  bus_rdata[CNT_W-1:0] = q.cap_a;
            A_CAPB:  bus_rdata[CNT_W-1:0] = q.cap_b;
            A_CNT:   bus_rdata[CNT_W-1:0] = q.cnt;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwcap_checks.sv
module pwcap_checks
    import pwcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_q,
    input logic             ug_req,
    input logic             per_evt,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] lim_eff,
    input logic [CNT_W-1:0] cap_a_q,
    input logic [CNT_W-1:0] cap_b_q,
    input logic [ST_W-1:0]  st_q,
    input logic [IEN_W-1:0] ien_q,
    input logic             irq
);
    assert_frozen_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !ug_req) |=> $stable(cnt_q));

    assert_frozen_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> ($stable(cap_a_q) && $stable(cap_b_q)));

    assert_wrap_at_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q[ST_WRAP]) |-> ($past(cnt_q) == $past(lim_eff)));

    assert_period_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> (cnt_q == '0));

    assert_overcap_a_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q[ST_OCA]) |-> $past(st_q[ST_CAPA]));

    assert_overcap_b_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q[ST_OCB]) |-> $past(st_q[ST_CAPB]));

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

    assert_ug_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ug_req && !st_q[ST_WRAP]) |=> (!st_q[ST_WRAP] && cnt_q == '0));
endmodule

bind pwcap_timer pwcap_checks #(.CNT_W(CNT_W)) u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_q  (q.run),
    .ug_req (ug_req),
    .per_evt(per_evt),
    .cnt_q  (q.cnt),
    .lim_eff(lim_eff),
    .cap_a_q(q.cap_a),
    .cap_b_q(q.cap_b),
    .st_q   (q.st),
    .ien_q  (q.ien),
    .irq    (irq)
);

// File: tb/test_pwcap_timer.sv
module test_pwcap_timer;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin = 2'b00;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwcap_timer i_pwcap_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin),
        .bus_we   (we),
        .bus_addr (addr),
        .bus_wdata(wdata),
        .bus_rdata(rdata),
        .irq      (irq)
    );

    localparam logic [4:0] CTRL = 5'h00, STAT = 5'h04, IEN = 5'h08, PSC = 5'h0C,
                           LIM = 5'h10, CAPA = 5'h14, CAPB = 5'h18, CNT = 5'h1C;
    localparam logic [31:0] RUN = 32'h1, SEL = 32'h2, LOW = 32'h4, UG = 32'h8;

    typedef struct packed {
        logic        sel;
        logic        low;
        logic [15:0] psc;
        logic [15:0] per;
        logic [15:0] wid;
        logic [31:0] exp_a;
        logic [31:0] exp_b;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 16'd0, 16'd20, 16'd7,  32'd19, 32'd6},
        '{1'b1, 1'b0, 16'd0, 16'd25, 16'd10, 32'd9,  32'd24},
        '{1'b0, 1'b1, 16'd0, 16'd16, 16'd5,  32'd15, 32'd4},
        '{1'b1, 1'b1, 16'd1, 16'd30, 16'd12, 32'd5,  32'd14},
        '{1'b0, 1'b0, 16'd3, 16'd40, 16'd9,  32'd9,  32'd2},
        '{1'b0, 1'b0, 16'd0, 16'd3,  16'd1,  32'd2,  32'd0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        we = 1'b1; addr = a; wdata = v;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic pulse(input int hi, input int lo);
        @(posedge clk); #1; pin[0] = 1'b1;
        repeat (hi) @(posedge clk);
        #1; pin[0] = 1'b0;
        repeat (lo) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] v, c0, a0, b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), v);
            chk($sformatf("R1 reg %0h after reset", i * 4), v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // vector table: R6 routing, R7 polarity, R8 capture values
        for (int n = 0; n < 6; n++) begin
            vec_t tv;
            tv = VECS[n];
            wr(CTRL, 32'h0);
            pin[tv.sel]  = tv.low;
            pin[!tv.sel] = 1'b0;
            repeat (4) @(posedge clk);
            #1;
            wr(PSC, {16'h0, tv.psc});
            wr(CTRL, UG | (tv.low ? LOW : 32'h0) | (tv.sel ? SEL : 32'h0));
            wr(CTRL, RUN | (tv.low ? LOW : 32'h0) | (tv.sel ? SEL : 32'h0));
            for (int c = 0; c < 3 * int'(tv.per); c++) begin
                @(posedge clk); #1;
                pin[tv.sel]  = ((c % int'(tv.per)) < int'(tv.wid)) ^ tv.low;
                pin[!tv.sel] = (c % 7) < 2;
            end
            repeat (5) @(posedge clk);
            #1;
            rd(CAPA, v);
            chk($sformatf("R8 R6 R7 vec%0d capture A", n), v, tv.exp_a);
            rd(CAPB, v);
            chk($sformatf("R8 R6 R7 vec%0d capture B", n), v, tv.exp_b);
        end
        wr(CTRL, 32'h0);
        pin = 2'b00;
        repeat (4) @(posedge clk);
        #1;

        // R3 zero limit acts as all ones
        wr(PSC, 32'h0);
        wr(LIM, 32'h0);
        wr(STAT, 32'h0);
        wr(CTRL, RUN | UG);
        repeat (40) @(posedge clk);
        rd(CNT, v);
        chk("R3 count with zero limit", v, 32'd40);
        rd(STAT, v);
        chk("R3 no wrap flag", v & 32'h4, 32'h0);

        // R5 update-generate clears counter, no flag
        wr(CTRL, RUN | UG);
        rd(CNT, v);
        chk("R5 counter cleared by update", v, 32'h0);
        rd(STAT, v);
        chk("R5 no wrap flag from update", v & 32'h4, 32'h0);
        rd(CTRL, v);
        chk("R5 update bit reads 0", v, RUN);

        // R2 prescaler preload
        wr(PSC, 32'd4);
        rd(CNT, c0);
        repeat (10) @(posedge clk);
        rd(CNT, v);
        chk("R2 old divider until update", v - c0, 32'd10);
        wr(CTRL, RUN | UG);
        repeat (10) @(posedge clk);
        rd(CNT, v);
        chk("R2 divide by five", v, 32'd2);

        // R4 wrap at the limit
        wr(PSC, 32'h0);
        wr(LIM, 32'd9);
        wr(STAT, 32'h0);
        wr(CTRL, RUN | UG);
        repeat (9) @(posedge clk);
        rd(STAT, v);
        chk("R4 no flag before wrap", v & 32'h4, 32'h0);
        rd(CNT, v);
        chk("R4 counter back to 0", v, 32'h0);
        rd(STAT, v);
        chk("R4 wrap flag set", v & 32'h4, 32'h4);

        // R10 interrupt gating, R9 write-0 clear
        wr(CTRL, 32'h0);
        @(negedge clk);
        chk("R10 irq low with no enable", {31'b0, irq}, 32'h0);
        wr(IEN, 32'h4);
        @(negedge clk);
        chk("R10 irq with wrap enable", {31'b0, irq}, 32'h1);
        wr(IEN, 32'h3);
        @(negedge clk);
        chk("R10 irq low with other enables", {31'b0, irq}, 32'h0);
        wr(IEN, 32'h4);
        wr(STAT, 32'hFFFF_FFFF);
        rd(STAT, v);
        chk("R9 writing ones keeps flag", v & 32'h4, 32'h4);
        chk("R9 irq still high", {31'b0, irq}, 32'h1);
        wr(STAT, ~32'h4);
        rd(STAT, v);
        chk("R9 writing zero clears flag", v & 32'h4, 32'h0);
        chk("R10 irq low after clear", {31'b0, irq}, 32'h0);

        // R11 stopped timer ignores the pins
        wr(STAT, 32'h0);
        rd(CNT, c0);
        rd(CAPA, a0);
        rd(CAPB, b0);
        for (int k = 0; k < 3; k++) pulse(4, 4);
        repeat (5) @(posedge clk);
        rd(CNT, v);
        chk("R11 counter frozen", v, c0);
        rd(CAPA, v);
        chk("R11 capture A frozen", v, a0);
        rd(CAPB, v);
        chk("R11 capture B frozen", v, b0);
        rd(STAT, v);
        chk("R11 no flags while stopped", v, 32'h0);

        // R12 over-capture
        wr(LIM, 32'h0);
        wr(CTRL, RUN);
        wr(STAT, 32'h0);
        pulse(5, 6);
        rd(STAT, v);
        chk("R12 single pulse flags", v, 32'h3);
        rd(CAPB, v);
        chk("R12 width of single pulse", v, 32'd4);
        pulse(5, 6);
        rd(STAT, v);
        chk("R12 over-capture bits", v, 32'h1B);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R1 watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule